// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the device-side command logic of a serial flash that handles erase work. It watches a single-line SPI port (mode 0: data in on the rising serial clock edge, data out on the falling edge) that the flash's own system clock oversamples. It decodes a small set of one-byte instructions: write enable, whole-array erase, sector erase with a 24-bit address, status read, suspend and resume. A self-timed down counter stands in for the array erase. It keeps a write enable latch and a write-in-progress flag, and these two flags are what software polls through the status read.

Whole-array erase is heavily gated. The instruction must end on exactly its eighth bit and the write enable latch must be set. All four block-protect inputs must be low, and no bit of the per-sector lock vector may be set. Once it starts, this erase runs to completion and cannot be suspended. A sector erase can be paused with the suspend instruction and continued with the resume instruction. During an erase the status read keeps working, and every other write-type instruction is dropped.

The array itself is not modelled. When an erase completes, the block raises a one-cycle completion strobe together with the kind of erase and the erased address. A whole-array completion means every byte of the array now reads FFh. None of the pins is a data stream, so there is no valid/ready pair: the SPI pins follow the serial protocol, and the other pins are plain control and status levels.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, wip, wel, suspended, erase_done and spi_miso are all 0.
- R2: Opcode 06h (write enable) sets wel. It only takes effect when chip select rises right after its eighth bit.
- R3: Opcode C7h (whole-array erase) starts an erase only if chip select rises after exactly 8 bits and wel is 1. When it ends on 7 or 9 bits, or wel is 0, it is discarded and wip stays 0.
- R4: A whole-array erase is also discarded unless bp_bits is 0000 and every bit of sector_lock is 0.
- R5: Opcode D8h (sector erase) needs exactly 32 bits: the opcode, then a 24-bit address sent MSB first. It also needs wel set. Address bit 23 is ignored and reported as 0. Bits 22:16 select the sector, and the erase is discarded if that sector's sector_lock bit is 1.
- R6: wip rises on the clock edge that detects chip select going high on an accepted erase. The timer then runs for exactly BULK_CYCLES (whole-array) or SECTOR_CYCLES (sector) clocks. On completion, erase_done pulses for one cycle with erase_bulk (1 = whole array, now all FFh) and erase_addr valid, and wip returns to 0.
- R7: wel is cleared on the same edge that accepts an erase.
- R8: While an erase is unfinished (running or suspended), the write-enable and erase instructions are ignored.
- R9: Opcode 05h (status read) drives the status byte {5'b0, suspended, wel, wip} on spi_miso, MSB first, one bit per falling serial clock edge. The byte repeats for as long as chip select stays low.
- R10: Opcode 75h suspends a running sector erase: suspended becomes 1, the timer holds its count, and wip stays 1. Opcode 7Ah resumes the erase, and it then finishes its remaining time.
- R11: Suspend has no effect on a whole-array erase.
- R12: If a suspend is decoded on the same clock edge as the final timer count, the completion takes effect and the suspend is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial instruction/address input |
| spi_miso | output | 1 | Serial status output |
| bp_bits | input | 4 | Block-protect bits; all must be 0 for a whole-array erase |
| sector_lock | input | NUM_SECTORS | Per-sector lock vector |
| wip | output | 1 | Erase in progress (running or suspended) |
| wel | output | 1 | Write enable latch |
| suspended | output | 1 | Sector erase is paused |
| erase_done | output | 1 | One-cycle completion strobe |
| erase_bulk | output | 1 | Kind of the last accepted erase: 1 = whole array |
| erase_addr | output | 24 | Address of the last accepted erase, bit 23 zero |

## Verification
Two functions can land on one clock edge: the timer's final count and a suspend instruction whose chip-select rise is decoded on that same edge. The bench times this on purpose. It holds chip select low after the eight suspend bits and counts the cycles wip has been high, then releases chip select so that the rise is seen exactly on the last count. It passes only if the completion strobe fires, suspended stays 0 and the erase lasted exactly its nominal length. A status read taken in the middle of a running erase also overlaps with the timer, and the bench checks that the shifted-out byte shows wip set and wel already cleared.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_BULK   = 8'hC7;
  localparam logic [7:0] OP_SECTOR = 8'hD8;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_SUSP   = 8'h75;
  localparam logic [7:0] OP_RESUME = 8'h7A;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_HOLD = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] addr,
  output logic              cs_end,
  output logic              sclk_fall
);
  logic sclk_q, cs_q, sclk_rise;
  logic [ADDR_W-1:0] shreg;

  assign sclk_rise = ~cs_n & sclk & ~sclk_q;
  assign sclk_fall = ~cs_n & ~sclk & sclk_q;
  assign cs_end    = cs_n & ~cs_q;
  assign addr      = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      bit_cnt <= '0;
      shreg   <= '0;
      opcode  <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[ADDR_W-2:0], mosi};
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(7)) opcode <= {shreg[6:0], mosi};
      end
    end
  end
endmodule

// File: rtl/status_shifter.sv
module status_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       shift_en,
  input  logic [7:0] status,
  output logic       miso
);
  logic [2:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= 3'd7;
      miso <= 1'b0;
    end else if (cs_n) begin
      ptr <= 3'd7;
    end else if (shift_en) begin
      miso <= status[ptr];
      ptr  <= ptr - 3'd1;
    end
  end
endmodule

// File: rtl/erase_timer.sv
module erase_timer
  import flash_erase_pkg::*;
#(
  parameter int BULK_CYCLES   = 2000,
  parameter int SECTOR_CYCLES = 500,
  parameter int ADDR_W        = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_bulk,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              suspend_req,
  input  logic              resume_req,
  output logic              busy,
  output logic              held,
  output logic              done,
  output logic              bulk,
  output logic [ADDR_W-1:0] addr
);
  localparam int MAXC = (BULK_CYCLES > SECTOR_CYCLES) ? BULK_CYCLES : SECTOR_CYCLES;
  localparam int TW   = $clog2(MAXC + 1);

  eng_state_t    state;
  logic [TW-1:0] remain;

  assign busy = (state != ENG_IDLE);
  assign held = (state == ENG_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      remain <= '0;
      done   <= 1'b0;
      bulk   <= 1'b0;
      addr   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ENG_IDLE: if (start) begin
          state  <= ENG_RUN;
          bulk   <= start_bulk;
          addr   <= start_addr;
          remain <= start_bulk ? TW'(BULK_CYCLES) : TW'(SECTOR_CYCLES);
        end
        ENG_RUN: begin
          if (remain == TW'(1)) begin
            state <= ENG_IDLE;
            done  <= 1'b1;
          end else begin
            remain <= remain - 1'b1;
            if (suspend_req && !bulk) state <= ENG_HOLD;
          end
        end
        ENG_HOLD: if (resume_req) state <= ENG_RUN;
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int NUM_SECTORS   = 128,
  parameter int SECTOR_SHIFT  = 16,
  parameter int BULK_CYCLES   = 2000,
  parameter int SECTOR_CYCLES = 500
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_cs_n,
  input  logic                   spi_sclk,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  input  logic [3:0]             bp_bits,
  input  logic [NUM_SECTORS-1:0] sector_lock,
  output logic                   wip,
  output logic                   wel,
  output logic                   suspended,
  output logic                   erase_done,
  output logic                   erase_bulk,
  output logic [23:0]            erase_addr
);
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 6;
  localparam int SEC_W  = $clog2(NUM_SECTORS);

  logic [CNT_W-1:0]  bit_cnt;
  logic [7:0]        opcode;
  logic [ADDR_W-1:0] raw_addr, addr_eff;
  logic              cs_end, sclk_fall;
  logic              cmd8, cmd32, wren_ok, bulk_ok, sect_ok, read_mode;
  logic              wel_q;
  logic [SEC_W-1:0]  sec_idx;

  spi_cmd_shifter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .bit_cnt(bit_cnt), .opcode(opcode), .addr(raw_addr),
    .cs_end(cs_end), .sclk_fall(sclk_fall)
  );

  assign addr_eff = raw_addr & 24'h7F_FFFF;
  assign sec_idx  = addr_eff[SECTOR_SHIFT +: SEC_W];

  assign cmd8    = cs_end && (bit_cnt == CNT_W'(8));
  assign cmd32   = cs_end && (bit_cnt == CNT_W'(32));
  assign wren_ok = cmd8 && (opcode == OP_WREN) && !wip;
  assign bulk_ok = cmd8 && (opcode == OP_BULK) && wel_q && !wip
                   && (bp_bits == 4'h0) && !(|sector_lock);
  assign sect_ok = cmd32 && (opcode == OP_SECTOR) && wel_q && !wip
                   && !sector_lock[sec_idx];
  assign read_mode = (bit_cnt >= CNT_W'(8)) && (opcode == OP_RDSR);

  always_ff @(posedge clk) begin
    if (!rst_n)                  wel_q <= 1'b0;
    else if (bulk_ok || sect_ok) wel_q <= 1'b0;
    else if (wren_ok)            wel_q <= 1'b1;
  end
  assign wel = wel_q;

  erase_timer #(
    .BULK_CYCLES(BULK_CYCLES), .SECTOR_CYCLES(SECTOR_CYCLES), .ADDR_W(ADDR_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(bulk_ok || sect_ok), .start_bulk(bulk_ok),
    .start_addr(bulk_ok ? '0 : addr_eff),
    .suspend_req(cmd8 && (opcode == OP_SUSP)),
    .resume_req(cmd8 && (opcode == OP_RESUME)),
    .busy(wip), .held(suspended), .done(erase_done),
    .bulk(erase_bulk), .addr(erase_addr)
  );

  status_shifter u_status (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n),
    .shift_en(sclk_fall && read_mode),
    .status({5'b0, suspended, wel_q, wip}),
    .miso(spi_miso)
  );
endmodule

// File: rtl/erase_ctrl_checker.sv
module erase_ctrl_checker #(
  parameter int NUM_SECTORS   = 128,
  parameter int BULK_CYCLES   = 2000,
  parameter int SECTOR_CYCLES = 500
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   spi_cs_n,
  input logic [3:0]             bp_bits,
  input logic [NUM_SECTORS-1:0] sector_lock,
  input logic                   wip,
  input logic                   wel,
  input logic                   suspended,
  input logic                   erase_done,
  input logic                   erase_bulk
);
  localparam int MAXC = (BULK_CYCLES > SECTOR_CYCLES) ? BULK_CYCLES : SECTOR_CYCLES;
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)                 run_len <= 0;
    else if (wip && !suspended) run_len <= run_len + 1;
    else if (!wip)              run_len <= 0;
  end

  // R6
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n) run_len <= MAXC);

  // R6
  start_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> ($past(spi_cs_n) && !$past(spi_cs_n, 2)));

  // R7
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !wel);

  // R4
  bulk_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wip) && erase_bulk) |-> (($past(bp_bits) == 4'h0) && ($past(sector_lock) == '0)));

  // R11
  no_bulk_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (wip && !erase_bulk));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |-> (!wip && !suspended) ##1 !erase_done);
endmodule

bind flash_erase_ctrl erase_ctrl_checker #(
  .NUM_SECTORS(NUM_SECTORS), .BULK_CYCLES(BULK_CYCLES), .SECTOR_CYCLES(SECTOR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .bp_bits(bp_bits),
  .sector_lock(sector_lock), .wip(wip), .wel(wel), .suspended(suspended),
  .erase_done(erase_done), .erase_bulk(erase_bulk)
);

// File: tb/tb_flash_erase_ctrl.sv
module tb_flash_erase_ctrl;
  localparam int NSEC = 128;
  localparam int BULK = 300;
  localparam int SECT = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [3:0] bp = 4'h0;
  logic [NSEC-1:0] lock = '0;
  logic miso, wip, wel, susp, done, bulk;
  logic [23:0] eaddr;
  int checks = 0, failures = 0, wtot = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (wip) wtot <= wtot + 1;

  flash_erase_ctrl #(.NUM_SECTORS(NSEC), .SECTOR_SHIFT(16),
    .BULK_CYCLES(BULK), .SECTOR_CYCLES(SECT)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .bp_bits(bp), .sector_lock(lock), .wip(wip), .wel(wel),
    .suspended(susp), .erase_done(done), .erase_bulk(bulk), .erase_addr(eaddr));

  typedef struct packed {
    logic [31:0] frame;
    logic [5:0]  nbits;
    logic        wren;
    logic [3:0]  bpv;
    logic        lock5;
    logic        exp_start;
    logic        exp_bulk;
    logic [23:0] exp_addr;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{32'hC700_0000, 6'd8,  1'b1, 4'h0, 1'b0, 1'b1, 1'b1, 24'h00_0000},
    '{32'hC700_0000, 6'd8,  1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 24'h00_0000},
    '{32'hC700_0000, 6'd7,  1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 24'h00_0000},
    '{32'hC700_0000, 6'd9,  1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 24'h00_0000},
    '{32'hC700_0000, 6'd8,  1'b1, 4'h4, 1'b0, 1'b0, 1'b0, 24'h00_0000},
    '{32'hC700_0000, 6'd8,  1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 24'h00_0000},
    '{32'hD805_0000, 6'd32, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 24'h05_0000},
    '{32'hD805_0000, 6'd32, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 24'h00_0000},
    '{32'hD885_1234, 6'd32, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 24'h05_1234},
    '{32'hD805_0000, 6'd32, 1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 24'h00_0000},
    '{32'hD806_0000, 6'd32, 1'b1, 4'h0, 1'b1, 1'b1, 1'b0, 24'h06_0000},
    '{32'hD806_0000, 6'd31, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 24'h00_0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [31:0] frame, input int nbits, input bit close);
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = frame[31-i];
      repeat (2) @(negedge clk); sclk = 1'b1;
      repeat (2) @(negedge clk); sclk = 1'b0;
    end
    if (close) begin
      repeat (2) @(negedge clk); cs_n = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic read_status(input int nbytes, output logic [7:0] last);
    spi_frame(32'h0500_0000, 8, 1'b0);
    last = '0;
    for (int b = 0; b < nbytes; b++) begin
      for (int i = 0; i < 8; i++) begin
        repeat (2) @(negedge clk);
        last = {last[6:0], miso};
        sclk = 1'b1;
        repeat (2) @(negedge clk); sclk = 1'b0;
      end
    end
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_done(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] st;
    bit seen;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({wip, wel, susp, done, miso} == 5'b0, "R1", {wip, wel, susp, done, miso}, 0);

    // R2, R9: write enable then status read, two repeated bytes
    spi_frame(32'h0600_0000, 8, 1'b1);
    chk(wel == 1'b1, "R2", wel, 1);
    read_status(2, st);
    chk(st == 8'h02, "R9", st, 8'h02);

    // Table of vectors: R3 R4 R5 R6 R7
    foreach (VECS[k]) begin
      if (VECS[k].wren) spi_frame(32'h0600_0000, 8, 1'b1);
      bp   = VECS[k].bpv;
      lock = VECS[k].lock5 ? (NSEC'(1) << 5) : '0;
      base = wtot;
      spi_frame(VECS[k].frame, int'(VECS[k].nbits), 1'b1);
      chk(wip == VECS[k].exp_start, "R3 R4 R5 start", wip, VECS[k].exp_start);
      if (VECS[k].exp_start) begin
        chk(wel == 1'b0, "R7", wel, 0);
        wait_done(BULK + 50, seen);
        chk(seen, "R6 done", seen, 1);
        chk(bulk == VECS[k].exp_bulk, "R6 kind", bulk, VECS[k].exp_bulk);
        if (!VECS[k].exp_bulk) chk(eaddr == VECS[k].exp_addr, "R5 addr", eaddr, VECS[k].exp_addr);
        chk(wtot - base == (VECS[k].exp_bulk ? BULK : SECT), "R6 length",
            wtot - base, VECS[k].exp_bulk ? BULK : SECT);
      end
      bp = 4'h0; lock = '0;
    end

    // R8, R9: busy drops write enable and erase, status still readable
    spi_frame(32'h0600_0000, 8, 1'b1);
    spi_frame(32'hD801_0000, 32, 1'b1);
    read_status(1, st);
    chk(st == 8'h01, "R9 busy", st, 8'h01);
    spi_frame(32'h0600_0000, 8, 1'b1);
    chk(wel == 1'b0, "R8 wren", wel, 0);
    spi_frame(32'hC700_0000, 8, 1'b1);
    wait_done(SECT + 50, seen);
    chk(seen && bulk == 1'b0, "R8 erase", {seen, bulk}, 2'b10);
    @(negedge clk);
    chk({wip, wel} == 2'b00, "R8 idle", {wip, wel}, 0);

    // R10: suspend and resume a sector erase
    spi_frame(32'h0600_0000, 8, 1'b1);
    spi_frame(32'hD802_0000, 32, 1'b1);
    spi_frame(32'h7500_0000, 8, 1'b1);
    chk({susp, wip} == 2'b11, "R10 suspend", {susp, wip}, 2'b11);
    read_status(1, st);
    chk(st == 8'h05, "R10 R9 status", st, 8'h05);
    wait_done(SECT + 20, seen);
    chk(!seen && susp, "R10 held", {seen, susp}, 2'b01);
    spi_frame(32'h7A00_0000, 8, 1'b1);
    chk(susp == 1'b0, "R10 resume", susp, 0);
    wait_done(SECT + 20, seen);
    chk(seen && eaddr == 24'h02_0000, "R10 finish", eaddr, 24'h02_0000);

    // R11: suspend ignored on whole-array erase
    spi_frame(32'h0600_0000, 8, 1'b1);
    spi_frame(32'hC700_0000, 8, 1'b1);
    spi_frame(32'h7500_0000, 8, 1'b1);
    chk(susp == 1'b0 && wip, "R11", {susp, wip}, 2'b01);
    wait_done(BULK + 20, seen);
    chk(seen && bulk, "R11 done", {seen, bulk}, 2'b11);

    // R12: suspend decoded on the final count
    spi_frame(32'h0600_0000, 8, 1'b1);
    base = wtot;
    spi_frame(32'hD803_0000, 32, 1'b1);
    spi_frame(32'h7500_0000, 8, 1'b0);
    while (wtot - base < SECT - 1) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(done && !susp && !wip, "R12", {done, susp, wip}, 3'b100);
    chk(wtot - base == SECT, "R12 length", wtot - base, SECT);
    repeat (4) @(negedge clk);
    chk(!susp && !wip, "R12 idle", {susp, wip}, 0);

    finish_run();
  end
endmodule